// File: doc/BRIEF.md
# SPI-Framed GPIO and Channel Exchanger

This block is an SPI slave that trades one fixed 24-bit frame with an external controller on every chip-select period. The frame is three bytes: a status byte, a channel 0 byte and a channel 1 byte, all sent most significant bit first. As the controller shifts its frame in, the block shifts its own frame out. The outgoing status byte carries the six local general-purpose inputs and one pending flag for each channel. The two outgoing data bytes come from local transmit buffers.

The SPI lines run in mode 0: the clock idles low, the block samples MOSI on a rising SCK edge and changes MISO on a falling edge. All three incoming SPI lines pass through a two-stage synchroniser into the system clock, so SCK must be well below half the system clock rate. Local logic fills a transmit buffer with a one-cycle write strobe, which marks that channel as pending. Once a full frame has been received, the block registers the six received general-purpose bits to its outputs. For each channel whose received flag is set, it also registers the channel byte and pulses that channel's valid strobe.

Top module: `spi_gpio_exchanger`

## Requirements
- R1: A frame is 24 bits, most significant bit first. The bits shifted out on MISO are, in order: channel 0 pending flag, channel 1 pending flag, gpio_in[5:0], transmit buffer 0 [7:0], then transmit buffer 1 [7:0]. The first bit is on MISO before the first rising SCK edge. MISO is 0 while chip select is deasserted.
- R2: In the received status byte (the first byte), bit 7 is the channel 0 flag, bit 6 is the channel 1 flag and bits 5..0 are the general-purpose bits. gpio_out takes bits 5..0 after every complete frame.
- R3: After a complete frame with a channel's flag set, that channel's data output takes the received byte, and its valid strobe is high for exactly one system clock cycle.
- R4: After a complete frame with a channel's flag clear, that channel's data output keeps its old value and its valid strobe does not fire.
- R5: If chip select is deasserted before 24 rising SCK edges, the frame is discarded. No output changes and no strobe fires.
- R6: Rising SCK edges after the 24th within one chip-select period are ignored. They do not change the latched outputs and do not start a second frame.
- R7: A write strobe loads its channel's transmit buffer and sets that channel's pending flag. A complete frame clears the flag.
- R8: A write made while a frame is in progress keeps that channel's pending flag set after the frame ends. The new data is sent in the next frame.
- R9: An aborted frame leaves both pending flags unchanged.
- R10: After reset: gpio_out, both data outputs, both strobes and both pending flags are 0, and the transmit buffers hold 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | SPI clock from the controller (mode 0) |
| spi_mosi | input | 1 | Serial data in |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_miso | output | 1 | Serial data out |
| gpio_in | input | 6 | Local inputs reported in the status byte |
| gpio_out | output | 6 | General-purpose bits from the last complete frame |
| tx0_wr | input | 1 | Load strobe for transmit buffer 0 |
| tx0_data | input | 8 | Byte for transmit buffer 0 |
| tx1_wr | input | 1 | Load strobe for transmit buffer 1 |
| tx1_data | input | 8 | Byte for transmit buffer 1 |
| rx0_data | output | 8 | Last flagged channel 0 byte |
| rx0_valid | output | 1 | One-cycle strobe for a new channel 0 byte |
| rx1_data | output | 8 | Last flagged channel 1 byte |
| rx1_valid | output | 1 | One-cycle strobe for a new channel 1 byte |

## Verification
The bench aborts a frame after 12 bits. A design that counts bits wrongly or keeps state across chip select would update outputs or clear pending flags here. It also sends 30 clock edges in one select period, so a counter that wraps would start a second, shifted frame. It writes a buffer during a live frame: a design that clears pending flags blindly at frame end would drop that byte, and the next status byte would show it. Frames with each flag clear check that data outputs hold and strobes stay quiet. A strobe monitor fails any strobe longer than one cycle.

// File: rtl/spx_pkg.sv
package spx_pkg;
  localparam int unsigned FRAME_BYTES = 3;

  function automatic int unsigned frame_bits(input int unsigned byte_w);
    return FRAME_BYTES * byte_w;
  endfunction
endpackage

// File: rtl/spx_sync.sv
module spx_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] INIT  = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam int unsigned CHAIN_W = W * STAGES;

  logic [CHAIN_W-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= INIT;
        else     chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= {STAGES{INIT}};
        else     chain <= {chain[CHAIN_W-W-1:0], d};
      end
    end
  endgenerate

  assign q = chain[CHAIN_W-1 -: W];
endmodule

// File: rtl/spx_shift.sv
module spx_shift #(
  parameter int unsigned DATA_W = 8
) (
  input  logic                                    clk,
  input  logic                                    rst,
  input  logic                                    sck_s,
  input  logic                                    mosi_s,
  input  logic                                    cs_n_s,
  input  logic [spx_pkg::frame_bits(DATA_W)-1:0]  load_word,
  output logic                                    miso,
  output logic                                    frame_done,
  output logic [spx_pkg::frame_bits(DATA_W)-1:0]  rx_word
);
  localparam int unsigned FRAME = spx_pkg::frame_bits(DATA_W);
  localparam int unsigned CW    = $clog2(FRAME + 1);

  logic            sck_d;
  logic [CW-1:0]   bit_cnt;
  logic [FRAME-1:0] tx_sr;
  logic [FRAME-1:0] rx_sr;
  logic            sck_rise;
  logic            sck_fall;
  logic            in_frame;

  assign sck_rise = sck_s & ~sck_d;
  assign sck_fall = ~sck_s & sck_d;
  assign in_frame = bit_cnt < CW'(FRAME);

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d      <= 1'b0;
      bit_cnt    <= '0;
      tx_sr      <= '0;
      rx_sr      <= '0;
      frame_done <= 1'b0;
    end else begin
      sck_d      <= sck_s;
      frame_done <= 1'b0;
      if (cs_n_s) begin
        bit_cnt <= '0;
        tx_sr   <= load_word;
      end else begin
        if (sck_rise && in_frame) begin
          rx_sr   <= {rx_sr[FRAME-2:0], mosi_s};
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == CW'(FRAME - 1)) frame_done <= 1'b1;
        end
        if (sck_fall && in_frame) tx_sr <= {tx_sr[FRAME-2:0], 1'b0};
      end
    end
  end

  assign miso    = cs_n_s ? 1'b0 : tx_sr[FRAME-1];
  assign rx_word = rx_sr;

  assert_count_bound_R6: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= CW'(FRAME));

  assert_idle_reset_R5: assert property (@(posedge clk) disable iff (rst)
    cs_n_s |=> (bit_cnt == '0) && !frame_done);
endmodule

// File: rtl/spi_gpio_exchanger.sv
module spi_gpio_exchanger #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sck,
  input  logic              spi_mosi,
  input  logic              spi_cs_n,
  output logic              spi_miso,
  input  logic [DATA_W-3:0] gpio_in,
  output logic [DATA_W-3:0] gpio_out,
  input  logic              tx0_wr,
  input  logic [DATA_W-1:0] tx0_data,
  input  logic              tx1_wr,
  input  logic [DATA_W-1:0] tx1_data,
  output logic [DATA_W-1:0] rx0_data,
  output logic              rx0_valid,
  output logic [DATA_W-1:0] rx1_data,
  output logic              rx1_valid
);
  localparam int unsigned FRAME  = spx_pkg::frame_bits(DATA_W);
  localparam int unsigned GPIO_W = DATA_W - 2;
  localparam int unsigned FLAG0  = FRAME - 1;
  localparam int unsigned FLAG1  = FRAME - 2;

  logic [2:0]       sync_q;
  logic             sck_s, mosi_s, cs_n_s;
  logic             frame_done;
  logic [FRAME-1:0] frame_word;
  logic [FRAME-1:0] load_word;
  logic [DATA_W-1:0] buf0, buf1;
  logic             pend0, pend1;
  logic             fresh0, fresh1;

  spx_sync #(.W(3), .STAGES(SYNC_STAGES), .INIT(3'b100)) i_sync (
    .clk (clk),
    .rst (rst),
    .d   ({spi_cs_n, spi_sck, spi_mosi}),
    .q   (sync_q)
  );
  assign {cs_n_s, sck_s, mosi_s} = sync_q;

  assign load_word = {pend0, pend1, gpio_in, buf0, buf1};

  spx_shift #(.DATA_W(DATA_W)) i_shift (
    .clk        (clk),
    .rst        (rst),
    .sck_s      (sck_s),
    .mosi_s     (mosi_s),
    .cs_n_s     (cs_n_s),
    .load_word  (load_word),
    .miso       (spi_miso),
    .frame_done (frame_done),
    .rx_word    (frame_word)
  );

  // Transmit buffers; a write after the frame snapshot survives frame end.
  always_ff @(posedge clk) begin
    if (rst) begin
      buf0 <= '0; buf1 <= '0;
      pend0 <= 1'b0; pend1 <= 1'b0;
      fresh0 <= 1'b0; fresh1 <= 1'b0;
    end else begin
      if (tx0_wr) buf0 <= tx0_data;
      if (tx1_wr) buf1 <= tx1_data;

      if (tx0_wr)          pend0 <= 1'b1;
      else if (frame_done) pend0 <= fresh0;
      if (tx1_wr)          pend1 <= 1'b1;
      else if (frame_done) pend1 <= fresh1;

      if (frame_done || cs_n_s) fresh0 <= 1'b0;
      else if (tx0_wr)          fresh0 <= 1'b1;
      if (frame_done || cs_n_s) fresh1 <= 1'b0;
      else if (tx1_wr)          fresh1 <= 1'b1;
    end
  end

  // Output latching on frame completion.
  always_ff @(posedge clk) begin
    if (rst) begin
      gpio_out  <= '0;
      rx0_data  <= '0;
      rx1_data  <= '0;
      rx0_valid <= 1'b0;
      rx1_valid <= 1'b0;
    end else begin
      rx0_valid <= 1'b0;
      rx1_valid <= 1'b0;
      if (frame_done) begin
        gpio_out <= frame_word[2*DATA_W +: GPIO_W];
        if (frame_word[FLAG0]) begin
          rx0_data  <= frame_word[DATA_W +: DATA_W];
          rx0_valid <= 1'b1;
        end
        if (frame_word[FLAG1]) begin
          rx1_data  <= frame_word[0 +: DATA_W];
          rx1_valid <= 1'b1;
        end
      end
    end
  end

  assert_strobe_single_R3: assert property (@(posedge clk) disable iff (rst)
    (rx0_valid |=> !rx0_valid) and (rx1_valid |=> !rx1_valid));

  assert_data_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !rx1_valid |-> $stable(rx1_data));

  assert_pending_set_R7: assert property (@(posedge clk) disable iff (rst)
    tx0_wr |=> pend0);

  assert_gpio_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !$past(frame_done) |-> $stable(gpio_out));
endmodule

// File: tb/test_spi_gpio_exchanger.sv
`timescale 1ns/1ps
module test_spi_gpio_exchanger;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spi_sck = 1'b0, spi_mosi = 1'b0, spi_cs_n = 1'b1;
  logic spi_miso;
  logic [5:0] gpio_in = '0;
  logic [5:0] gpio_out;
  logic tx0_wr = 1'b0, tx1_wr = 1'b0;
  logic [7:0] tx0_data = '0, tx1_data = '0;
  logic [7:0] rx0_data, rx1_data;
  logic rx0_valid, rx1_valid;

  int checks = 0;
  int errors = 0;
  int p0 = 0, p1 = 0;
  logic prev0 = 1'b0, prev1 = 1'b0;

  // reference model state
  logic m_pend0 = 0, m_pend1 = 0;
  logic [7:0] m_buf0 = 0, m_buf1 = 0, m_rx0 = 0, m_rx1 = 0;
  logic [5:0] m_gpio = 0;

  always #2.5 clk = ~clk;

  spi_gpio_exchanger i_spi_gpio_exchanger (
    .clk(clk), .rst(rst), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_cs_n(spi_cs_n), .spi_miso(spi_miso), .gpio_in(gpio_in),
    .gpio_out(gpio_out), .tx0_wr(tx0_wr), .tx0_data(tx0_data),
    .tx1_wr(tx1_wr), .tx1_data(tx1_data), .rx0_data(rx0_data),
    .rx0_valid(rx0_valid), .rx1_data(rx1_data), .rx1_valid(rx1_valid)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Per-clock strobe monitor: counts pulses and checks their width (R3).
  always @(negedge clk) begin
    if (!rst) begin
      if (rx0_valid) begin p0++; chk(!prev0, "R3 strobe0 width", 32'(prev0), 0); end
      if (rx1_valid) begin p1++; chk(!prev1, "R3 strobe1 width", 32'(prev1), 0); end
    end
    prev0 = rx0_valid;
    prev1 = rx1_valid;
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_ch(input int ch, input logic [7:0] v);
    @(negedge clk);
    if (ch == 0) begin tx0_wr = 1; tx0_data = v; m_buf0 = v; m_pend0 = 1; end
    else         begin tx1_wr = 1; tx1_data = v; m_buf1 = v; m_pend1 = 1; end
    @(negedge clk);
    tx0_wr = 0; tx1_wr = 0;
  endtask

  // One select period: nbits SCK cycles; optional channel 1 write before bit wr_at.
  task automatic frame(input logic [23:0] mo, input int nbits, input int wr_at,
                       input logic [7:0] wr_val, input string tag);
    logic [23:0] exp_miso, got, mask;
    bit wrote;
    bit e0, e1;
    wrote = 0; got = '0;
    exp_miso = {m_pend0, m_pend1, gpio_in, m_buf0, m_buf1};
    p0 = 0; p1 = 0;
    spi_cs_n = 0;
    wait_clk(8);
    for (int i = 0; i < nbits; i++) begin
      if (i == wr_at) begin
        write_ch(1, wr_val);
        wrote = 1;
      end
      spi_mosi = (i < 24) ? mo[23-i] : ~spi_mosi;
      wait_clk(8);
      if (i < 24) got[23-i] = spi_miso;
      spi_sck = 1;
      wait_clk(8);
      spi_sck = 0;
      wait_clk(8);
    end
    spi_cs_n = 1;
    wait_clk(12);
    mask = (nbits >= 24) ? 24'hFFFFFF : ~(24'hFFFFFF >> nbits);
    chk((got & mask) == (exp_miso & mask), {"R1 miso ", tag}, 32'(got & mask), 32'(exp_miso & mask));
    e0 = 0; e1 = 0;
    if (nbits >= 24) begin
      m_gpio = mo[21:16];
      if (mo[23]) begin m_rx0 = mo[15:8]; e0 = 1; end
      if (mo[22]) begin m_rx1 = mo[7:0];  e1 = 1; end
      m_pend0 = 0;
      m_pend1 = wrote;
    end
    chk(gpio_out == m_gpio, {"R2 gpio_out ", tag}, 32'(gpio_out), 32'(m_gpio));
    chk(rx0_data == m_rx0, {"R3/R4 rx0_data ", tag}, 32'(rx0_data), 32'(m_rx0));
    chk(rx1_data == m_rx1, {"R3/R4 rx1_data ", tag}, 32'(rx1_data), 32'(m_rx1));
    chk(p0 == int'(e0), {"R3/R4/R5 rx0 strobes ", tag}, 32'(p0), 32'(e0));
    chk(p1 == int'(e1), {"R3/R4/R5 rx1 strobes ", tag}, 32'(p1), 32'(e1));
  endtask

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait_clk(5);
    rst = 0;
    wait_clk(4);
    // R10 reset state
    chk(gpio_out == 0 && rx0_data == 0 && rx1_data == 0, "R10 outputs",
        32'({gpio_out, rx0_data, rx1_data}), 0);
    chk(!rx0_valid && !rx1_valid && !spi_miso, "R10 strobes/miso",
        32'({rx0_valid, rx1_valid, spi_miso}), 0);

    // Both flags set, nothing pending (R1, R2, R3, R10 buffers)
    gpio_in = 6'h2A;
    frame({2'b11, 6'h15, 8'h5A, 8'hA5}, 24, -1, 8'h00, "both");

    // Writes set pending (R7); only channel 0 flagged (R4)
    write_ch(0, 8'h3C);
    write_ch(1, 8'hC3);
    gpio_in = 6'h11;
    frame({2'b10, 6'h3F, 8'h11, 8'h22}, 24, -1, 8'h00, "R7 pending sent");

    // Pending cleared after frame (R7); only channel 1 flagged
    frame({2'b01, 6'h00, 8'h77, 8'h88}, 24, -1, 8'h00, "R7 pending cleared");

    // Abort after 12 bits (R5, R9)
    write_ch(0, 8'h99);
    frame({2'b11, 6'h2B, 8'hEE, 8'hDD}, 12, -1, 8'h00, "R5 abort");
    frame({2'b00, 6'h07, 8'h12, 8'h34}, 24, -1, 8'h00, "R9 pending kept");

    // Extra clocks in one select (R6)
    gpio_in = 6'h3E;
    frame({2'b11, 6'h19, 8'hC8, 8'h4D}, 30, -1, 8'h00, "R6 extra clocks");

    // Mid-frame write keeps pending (R8)
    frame({2'b00, 6'h05, 8'h00, 8'h00}, 24, 5, 8'hB7, "R8 write mid-frame");
    frame({2'b11, 6'h2C, 8'h61, 8'h62}, 24, -1, 8'h00, "R8 next frame");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule